// File: doc/BRIEF.md
# Low-toggle pseudorandom scan pattern generator

This block produces pseudorandom scan-load data whose switching activity can be set by the user. A 32-bit linear feedback shift register supplies fresh bits to a row of hold latches. Each latch either takes a new bit or keeps its previous value. A fixed XOR network combines the latch outputs into a wider set of scan-chain inputs. A scan chain fed only by frozen latches sees a constant value for the whole pattern, so fewer transparent latches mean fewer transitions during scan shift.

Two controls decide which latches move. The first is a per-latch mask. Weighted pseudorandom bits are shifted into a staging register on every shift cycle, and the mask is copied from that register at each pattern start. The weight input sets what fraction of the mask bits are 1. The second is a phase timer. Within each pattern it alternates between a toggle phase, where masked latches pass data, and a hold phase, where every latch is frozen. The lengths of both phases are programmable. They are captured into shadow copies at pattern start, so the values in force cannot change during capture or partway through a pattern.

The controller drives a pattern start strobe, asserts capture between shift windows, and loads a seed before the first pattern.

Top module: `lowtog_prpg`

## Requirements
- R1: A synchronous active-high reset has these effects. All latches, the mask, the staging register, the phase flip-flop, the phase counter and both shadow lengths become 0. The phase is hold. The generator register becomes 1. After reset, scan_out is all zeros.
- R2: When seed_load is high, the generator register takes `seed` on the next edge. A zero seed is replaced by 1. No other state changes in that cycle. seed_load has priority over pat_start, capture and shifting.
- R3: A cycle where none of seed_load, pat_start and capture is high is a shift cycle. In a shift cycle the generator shifts left with feedback g[31]^g[21]^g[1]^g[0] entering bit 0. Latch i is enabled only when mask bit i is 1 and the phase is toggle. An enabled latch takes the pre-shift generator bit 4*i.
- R4: A latch whose mask bit is 0 keeps its value for the whole pattern.
- R5: In every shift cycle, the staging register shifts left and a weighted bit enters bit 0. That bit is formed from the pre-shift generator bits as follows: weight 0 gives the AND of g[31:28], weight 1 the AND of g[31:29], weight 2 the AND of g[31:30], and weight 3 gives g[31]. The mask is loaded from the staging register only on a pattern-start cycle.
- R6: A pattern-start cycle (pat_start high, capture and seed_load low) advances neither the generator nor the latches. It stores hold_len and tog_len into the shadows and clears the phase counter. The following shift cycles run T toggle cycles, then H hold cycles, and repeat, where T and H are the stored lengths.
- R7: A stored length of 0 skips that phase. If T=0 and H>0, the pattern stays in hold. If H=0, the pattern stays in toggle. If both are 0, the pattern stays in toggle.
- R8: While capture is high, no state changes. A pat_start in such a cycle is ignored.
- R9: Changes to hold_len and tog_len between pattern starts have no effect on the running pattern.
- R10: Chain j is driven by the XOR of latches j mod 8, (j+1+j/8) mod 8 and (j+3+2*(j/8)) mod 8, where j/8 is integer division.
- R11: In the hold phase, every latch keeps its value, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load seed into generator |
| seed | input | 32 | Generator seed |
| pat_start | input | 1 | Pattern start strobe |
| capture | input | 1 | Capture strobe, freezes all state |
| weight | input | 2 | Mask weighting select |
| hold_len | input | 4 | Hold phase length in shift cycles |
| tog_len | input | 4 | Toggle phase length in shift cycles |
| scan_out | output | 16 | Scan chain data |

## Verification
Pattern start and capture can fall in the same cycle. In that case capture must win, and the strobe together with the new lengths offered in that cycle must be discarded. The bench provokes this by raising pat_start with different hold and toggle lengths during a multi-cycle capture. It then checks two things: scan_out stays frozen throughout, and the shift cycles that follow match a model that kept the earlier mask and lengths. Phase-boundary timing is judged cycle by cycle against the same model. It is also judged directly, by checking that scan_out does not move across the hold cycles.

// File: rtl/lowtog_prpg.sv
module lowtog_prpg #(
  parameter int NLATCH = 8,
  parameter int NCHAIN = 16,
  parameter int PER_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_load,
  input  logic [31:0]       seed,
  input  logic              pat_start,
  input  logic              capture,
  input  logic [1:0]        weight,
  input  logic [PER_W-1:0]  hold_len,
  input  logic [PER_W-1:0]  tog_len,
  output logic [NCHAIN-1:0] scan_out
);
  localparam int GW     = 32;
  localparam int STRIDE = GW / NLATCH;

  logic [GW-1:0]     gen;
  logic [NLATCH-1:0] lat, mask, stage, en;
  logic [PER_W-1:0]  hold_sh, tog_sh, cnt, cur_len, oth_len;
  logic              tphase, wbit, term, t_in, advance, start_ok, start_ph;

  assign advance  = ~seed_load & ~pat_start & ~capture;
  assign start_ok = pat_start & ~capture & ~seed_load;
  assign start_ph = ~((tog_len == '0) && (hold_len != '0));

  always_comb begin
    case (weight)
      2'd0:    wbit = &gen[GW-1:GW-4];
      2'd1:    wbit = &gen[GW-1:GW-3];
      2'd2:    wbit = &gen[GW-1:GW-2];
      default: wbit = gen[GW-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      gen <= {{(GW-1){1'b0}}, 1'b1};
    else if (seed_load)
      gen <= (seed == '0) ? {{(GW-1){1'b0}}, 1'b1} : seed;
    else if (advance)
      gen <= {gen[GW-2:0], gen[31] ^ gen[21] ^ gen[1] ^ gen[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      mask  <= '0;
    end else if (start_ok) begin
      mask <= stage;
    end else if (advance) begin
      stage <= {stage[NLATCH-2:0], wbit};
    end
  end

  assign en = mask & {NLATCH{tphase & advance}};

  genvar i;
  generate
    for (i = 0; i < NLATCH; i++) begin : g_lat
      always_ff @(posedge clk) begin
        if (rst)
          lat[i] <= 1'b0;
        else if (en[i])
          lat[i] <= gen[i*STRIDE];
      end
    end
  endgenerate

  assign cur_len = tphase ? tog_sh : hold_sh;
  assign oth_len = tphase ? hold_sh : tog_sh;
  assign term    = advance && (cur_len != '0) && (cnt == cur_len - 1'b1);
  assign t_in    = term && (oth_len != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tphase  <= 1'b0;
      cnt     <= '0;
      hold_sh <= '0;
      tog_sh  <= '0;
    end else if (start_ok) begin
      hold_sh <= hold_len;
      tog_sh  <= tog_len;
      cnt     <= '0;
      tphase  <= start_ph;
    end else if (advance && cur_len != '0) begin
      cnt <= term ? '0 : cnt + 1'b1;
      if (t_in) tphase <= ~tphase;
    end
  end

  genvar j;
  generate
    for (j = 0; j < NCHAIN; j++) begin : g_ps
      localparam int A = j % NLATCH;
      localparam int B = (j + 1 + j / NLATCH) % NLATCH;
      localparam int C = (j + 3 + 2 * (j / NLATCH)) % NLATCH;
      assign scan_out[j] = lat[A] ^ lat[B] ^ lat[C];
    end
  endgenerate

  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst) gen != '0); // R2
  AST_CAPTURE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (capture && !seed_load) |=> ($stable(gen) && $stable(lat) && $stable(mask) && $stable(tphase))); // R8
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!tphase) |=> $stable(lat)); // R11
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((lat ^ $past(lat)) & ~$past(mask)) == '0)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cur_len != '0) |-> (cnt < cur_len)); // R6
  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!start_ok) |=> ($stable(hold_sh) && $stable(tog_sh))); // R9
  AST_START_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> ($stable(gen) && $stable(lat))); // R6
endmodule

// File: tb/sim_lowtog_prpg.sv
module sim_lowtog_prpg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seed_load = 1'b0, pat_start = 1'b0, capture = 1'b0;
  logic [31:0] seed = '0;
  logic [1:0] weight = '0;
  logic [3:0] hold_len = '0, tog_len = '0;
  logic [15:0] scan_out;

  int nchk = 0, nfail = 0;

  lowtog_prpg u0 (.clk(clk), .rst(rst), .seed_load(seed_load), .seed(seed),
    .pat_start(pat_start), .capture(capture), .weight(weight),
    .hold_len(hold_len), .tog_len(tog_len), .scan_out(scan_out));

  always #5 clk = ~clk;

  logic [31:0] m_gen;
  logic [7:0]  m_lat, m_mask, m_stage;
  logic [3:0]  m_hs, m_ts, m_cnt;
  logic        m_ph;

  function automatic logic [15:0] m_scan(input logic [7:0] l);
    logic [15:0] s;
    for (int j = 0; j < 16; j++)
      s[j] = l[j % 8] ^ l[(j + 1 + j / 8) % 8] ^ l[(j + 3 + 2 * (j / 8)) % 8];
    return s;
  endfunction

  task automatic model;
    logic wb;
    logic [3:0] cl, ol;
    if (rst) begin
      m_gen = 32'd1; m_lat = '0; m_mask = '0; m_stage = '0;
      m_hs = '0; m_ts = '0; m_cnt = '0; m_ph = 1'b0;
    end else if (seed_load) begin
      m_gen = (seed == 0) ? 32'd1 : seed;
    end else if (capture) begin
    end else if (pat_start) begin
      m_mask = m_stage; m_hs = hold_len; m_ts = tog_len; m_cnt = '0;
      m_ph = !(tog_len == 0 && hold_len != 0);
    end else begin
      for (int i = 0; i < 8; i++)
        if (m_mask[i] && m_ph) m_lat[i] = m_gen[4*i];
      case (weight)
        2'd0: wb = m_gen[31] & m_gen[30] & m_gen[29] & m_gen[28];
        2'd1: wb = m_gen[31] & m_gen[30] & m_gen[29];
        2'd2: wb = m_gen[31] & m_gen[30];
        default: wb = m_gen[31];
      endcase
      m_stage = {m_stage[6:0], wb};
      m_gen = {m_gen[30:0], m_gen[31] ^ m_gen[21] ^ m_gen[1] ^ m_gen[0]};
      cl = m_ph ? m_ts : m_hs;
      ol = m_ph ? m_hs : m_ts;
      if (cl != 0) begin
        if (m_cnt == cl - 1) begin
          m_cnt = 0;
          if (ol != 0) m_ph = ~m_ph;
        end else m_cnt = m_cnt + 1;
      end
    end
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: scan_out=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic sl, input logic ps, input logic cp);
    seed_load = sl; pat_start = ps; capture = cp;
    @(posedge clk);
    model();
    @(negedge clk);
    seed_load = 1'b0; pat_start = 1'b0; capture = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      step(1'b0, 1'b0, 1'b0);
      check(tag, scan_out, m_scan(m_lat));
    end
  endtask

  // {seed, weight, hold, tog}
  localparam logic [41:0] VEC [6] = '{
    {32'hDEADBEEF, 2'd3, 4'd3, 4'd5},
    {32'h12345678, 2'd2, 4'd1, 4'd1},
    {32'hA5A5F00F, 2'd1, 4'd0, 4'd7},
    {32'h0F0F1234, 2'd0, 4'd6, 4'd2},
    {32'hCAFEBABE, 2'd3, 4'd15, 4'd15},
    {32'h87654321, 2'd3, 4'd2, 4'd0}
  };

  logic [15:0] snap;
  int moved;

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog: run did not end");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    check("R1 reset", scan_out, 16'h0000);

    for (int v = 0; v < 6; v++) begin
      seed = VEC[v][41:10]; weight = VEC[v][9:8];
      hold_len = VEC[v][7:4]; tog_len = VEC[v][3:0];
      step(1'b1, 1'b0, 1'b0);
      run(12, "R3 fill");
      step(1'b0, 1'b1, 1'b0);
      check("R6 start", scan_out, m_scan(m_lat));
      run(40, "R10 pattern");
      step(1'b0, 1'b1, 1'b0);
      run(30, "R5 second mask");
    end

    seed = 32'h0; weight = 2'd3;
    step(1'b1, 1'b0, 1'b0);
    run(20, "R2 zero seed");

    hold_len = 4'd3; tog_len = 4'd2;
    step(1'b0, 1'b1, 1'b0);
    run(2, "R6 toggle");
    snap = scan_out;
    run(3, "R11 hold");
    check("R11 frozen", scan_out, snap);

    tog_len = 4'd0; hold_len = 4'd4;
    run(4, "R3 pre");
    snap = scan_out;
    step(1'b0, 1'b1, 1'b0);
    moved = 0;
    for (int k = 0; k < 20; k++) begin
      step(1'b0, 1'b0, 1'b0);
      if (scan_out !== snap) moved++;
    end
    check("R7 hold only", 16'(moved), 16'd0);

    hold_len = 4'd0; tog_len = 4'd0;
    step(1'b0, 1'b1, 1'b0);
    run(15, "R7 both zero");

    weight = 2'd0;
    hold_len = 4'd2; tog_len = 4'd3;
    step(1'b0, 1'b1, 1'b0);
    run(5, "R4 weight0");
    hold_len = 4'd9; tog_len = 4'd1;
    run(20, "R9 mid change");

    snap = scan_out;
    seed = 32'h13579BDF;
    hold_len = 4'd1; tog_len = 4'd8;
    capture = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b1, 1'b1);
      check("R8 capture freeze", scan_out, snap);
    end
    run(25, "R8 after capture");

    step(1'b0, 1'b1, 1'b0);
    run(25, "R4 R5 final");

    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    check("R1 reset again", scan_out, 16'h0000);
    run(10, "R1 idle hold");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule